// File: doc/BRIEF.md
# Predicated Absolute-Value Min/Max Accumulator

This block updates one 128-bit vector register lane by lane. The destination vector D holds unsigned lanes. The source vector M holds signed lanes. For every lane the unit takes the magnitude of the source element and compares it, as an unsigned number, with the destination element. In max mode it keeps the larger of the two. In min mode it keeps the smaller. D is both an operand and the result, so repeated issues accumulate a running extreme of source magnitudes.

The lane width can be 8, 16 or 32 bits. A 16-bit predicate carries one enable per byte of the vector. Only enabled bytes receive the new value; disabled bytes pass the incoming D byte through unchanged. A one-cycle start pulse captures the operands. The merged vector is registered and appears on the next clock edge, together with a one-cycle done strobe.

Top module: `absmm_unit`

## Requirements
- R1: `size_i` selects the lane width: 2'b00 gives sixteen 8-bit lanes, 2'b01 gives eight 16-bit lanes and 2'b10 gives four 32-bit lanes. Lane e occupies bits [e*W +: W], where W is the lane width.
- R2: Each source lane is read as two's complement and replaced by its magnitude. The most negative value maps to the unsigned value 2^(W-1), for example 8'h80 gives 128. It is neither saturated nor wrapped.
- R3: Each destination lane is read as unsigned. The comparison with the source magnitude is unsigned, so a destination of 8'hF0 counts as 240.
- R4: When `op_min_i` is 0 each lane result is the unsigned maximum of D and |M|. When it is 1 the result is the unsigned minimum.
- R5: `pred_i[b]` governs byte b, which is bits [8b+7:8b]. Where the bit is 1 the byte takes the computed result. Where it is 0 the byte keeps the value of `vd_i`. This applies byte by byte even inside wider lanes.
- R6: A start captured at a rising edge produces the result on `vd_o` and a high `done_o` after that same edge. `done_o` is high in exactly the cycles that follow an edge at which `start_i` was high, so back-to-back starts give back-to-back results.
- R7: While `start_i` is low, `vd_o` holds its value, whatever the other inputs do.
- R8: Size code 2'b11 is reserved. A start with that code copies `vd_i` to `vd_o` unchanged and raises `illegal_o` in the same cycle as `done_o`. `illegal_o` is low after every start with a legal size.
- R9: A synchronous active-high `rst` clears `vd_o`, `done_o` and `illegal_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Capture the operands and compute |
| op_min_i | input | 1 | 0 selects max, 1 selects min |
| size_i | input | 2 | Lane width code |
| pred_i | input | 16 | Per-byte write enable |
| vd_i | input | 128 | Destination operand, unsigned lanes |
| vm_i | input | 128 | Source operand, signed lanes |
| vd_o | output | 128 | Registered updated destination |
| done_o | output | 1 | One-cycle result strobe |
| illegal_o | output | 1 | Reserved size seen, pulses with done |

## Verification
A wrong magnitude or a wrong comparison shows up in `vd_o` one cycle after the start. It appears only in enabled bytes, and only when the operands land on the affected side of the comparison. The bench therefore aims at the most negative source values, at destinations with the top bit set, and at partial predicates inside 16-bit and 32-bit lanes. A fault in the output register shows as a missing or extra `done_o` strobe, or as `vd_o` drifting during idle cycles. Both are visible within a cycle or two of the disturbance.

// File: rtl/absmm_pkg.sv
package absmm_pkg;
    localparam int VEC_W    = 128;
    localparam int BYTE_W   = 8;
    localparam int NUM_BYTE = VEC_W / BYTE_W;
    localparam int NUM_SZ   = 3;

    typedef enum logic [1:0] {
        SZ_B8   = 2'b00,
        SZ_B16  = 2'b01,
        SZ_B32  = 2'b10,
        SZ_RSVD = 2'b11
    } elem_sz_e;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             done;
        logic             illegal;
    } out_st_t;
endpackage

// File: rtl/absmm_lane.sv
module absmm_lane #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] d_i,
    input  logic [EW-1:0] m_i,
    input  logic          min_i,
    output logic [EW-1:0] r_o
);
    logic [EW-1:0] mag;
    logic          d_gt;

    always_comb begin
        mag  = m_i[EW-1] ? (~m_i + 1'b1) : m_i;
        d_gt = d_i > mag;
        r_o  = (d_gt ^ min_i) ? d_i : mag;
    end

    always_comb begin
        if (!$isunknown({d_i, m_i, min_i})) begin
            AST_LANE_EXTREME: assert (min_i ? (r_o <= d_i && r_o <= mag)
                                             : (r_o >= d_i && r_o >= mag)); // R4
            AST_MAG_RANGE: assert (!mag[EW-1] || (mag == {1'b1, {(EW-1){1'b0}}})); // R2
        end
    end
endmodule

// File: rtl/absmm_merge.sv
module absmm_merge
    import absmm_pkg::*;
(
    input  logic [VEC_W-1:0]    old_i,
    input  logic [VEC_W-1:0]    new_i,
    input  logic [NUM_BYTE-1:0] en_i,
    output logic [VEC_W-1:0]    out_o
);
    for (genvar b = 0; b < NUM_BYTE; b++) begin : g_byte
        assign out_o[b*BYTE_W +: BYTE_W] = en_i[b] ? new_i[b*BYTE_W +: BYTE_W]
                                                   : old_i[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/absmm_unit.sv
module absmm_unit
    import absmm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                op_min_i,
    input  logic [1:0]          size_i,
    input  logic [NUM_BYTE-1:0] pred_i,
    input  logic [VEC_W-1:0]    vd_i,
    input  logic [VEC_W-1:0]    vm_i,
    output logic [VEC_W-1:0]    vd_o,
    output logic                done_o,
    output logic                illegal_o
);
    logic [VEC_W-1:0] res_sz [NUM_SZ];
    logic [VEC_W-1:0] res_sel;
    logic [VEC_W-1:0] merged;
    logic             size_ok;
    out_st_t          st_d, st_q;

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
        localparam int EW    = BYTE_W << g;
        localparam int NLANE = VEC_W / EW;
        logic [VEC_W-1:0] res_g;
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            absmm_lane #(.EW(EW)) u_lane (
                .d_i   (vd_i[l*EW +: EW]),
                .m_i   (vm_i[l*EW +: EW]),
                .min_i (op_min_i),
                .r_o   (res_g[l*EW +: EW])
            );
        end
        assign res_sz[g] = res_g;
    end

    always_comb begin
        size_ok = 1'b1;
        case (elem_sz_e'(size_i))
            SZ_B8:   res_sel = res_sz[0];
            SZ_B16:  res_sel = res_sz[1];
            SZ_B32:  res_sel = res_sz[2];
            default: begin
                res_sel = vd_i;
                size_ok = 1'b0;
            end
        endcase
    end

    absmm_merge u_merge (
        .old_i (vd_i),
        .new_i (res_sel),
        .en_i  (pred_i),
        .out_o (merged)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        if (start_i) begin
            st_d.done    = 1'b1;
            st_d.illegal = !size_ok;
            st_d.vec     = size_ok ? merged : vd_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vd_o      = st_q.vec;
    assign done_o    = st_q.done;
    assign illegal_o = st_q.illegal;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(start_i) |-> done_o); // R6
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(vd_o)); // R7
    AST_RSVD_PASS: assert property (@(posedge clk) disable iff (rst)
        start_i && size_i == 2'b11 |=> illegal_o && vd_o == $past(vd_i)); // R8
    AST_LEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        start_i && size_i != 2'b11 |=> !illegal_o); // R8
    AST_IDLE_NO_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> !illegal_o); // R8
endmodule

// File: tb/absmm_unit_tb.sv
module absmm_unit_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         op_min_i = 1'b0;
    logic [1:0]   size_i = 2'b00;
    logic [15:0]  pred_i = '0;
    logic [127:0] vd_i = '0;
    logic [127:0] vm_i = '0;
    logic [127:0] vd_o;
    logic         done_o;
    logic         illegal_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [127:0] vec;
        logic         ill;
        string        tag;
    } exp_t;
    exp_t sbq [$];

    always #2 clk = ~clk;

    absmm_unit u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_min_i(op_min_i),
        .size_i(size_i), .pred_i(pred_i), .vd_i(vd_i), .vm_i(vm_i),
        .vd_o(vd_o), .done_o(done_o), .illegal_o(illegal_o)
    );

    function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] m,
                                           input logic [1:0] sz, input logic mn,
                                           input logic [15:0] p);
        logic [127:0] r;
        logic [127:0] out;
        int ew;
        if (sz == 2'b11) return d;
        ew = 8 << sz;
        r = '0;
        for (int e = 0; e < 128 / ew; e++) begin
            longint unsigned dv, mv, av, lim, rv;
            lim = 64'd1 << ew;
            dv = 0; mv = 0;
            for (int k = 0; k < ew; k++) begin
                dv[k] = d[e*ew + k];
                mv[k] = m[e*ew + k];
            end
            av = mv[ew-1] ? (lim - mv) : mv;
            if (mn) rv = (dv < av) ? dv : av;
            else    rv = (dv > av) ? dv : av;
            for (int k = 0; k < ew; k++) r[e*ew + k] = rv[k];
        end
        for (int b = 0; b < 16; b++)
            out[b*8 +: 8] = p[b] ? r[b*8 +: 8] : d[b*8 +: 8];
        return out;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [127:0] d, input logic [127:0] m, input logic [1:0] sz,
                         input logic mn, input logic [15:0] p, input string tag);
        exp_t it;
        it.vec = model(d, m, sz, mn, p);
        it.ill = (sz == 2'b11);
        it.tag = tag;
        sbq.push_back(it);
        vd_i = d; vm_i = m; size_i = sz; op_min_i = mn; pred_i = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor: pop an expectation for every done strobe
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R6 done without start", {127'd0, done_o}, 128'd0);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                check(vd_o === it.vec, it.tag, vd_o, it.vec);
                check(illegal_o === it.ill, {it.tag, " R8 illegal flag"},
                      {127'd0, illegal_o}, {127'd0, it.ill});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(vd_o === '0 && done_o === 1'b0 && illegal_o === 1'b0, "R9 reset state",
              {vd_o[125:0], done_o, illegal_o}, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R4 bytes, max, including -128 and -1
        do_op({16{8'h05}}, {8'h80, 8'hFF, 8'h7F, 8'h81, {12{8'hFB}}}, 2'b00, 1'b0,
              16'hFFFF, "R1 R2 R4 byte max");
        @(negedge clk);
        check(done_o === 1'b0, "R6 single done strobe", {127'd0, done_o}, 128'd0);
        // R3 unsigned destination vs magnitude, min mode
        do_op({16{8'hF0}}, {8'h80, 8'h10, 8'hF0, {13{8'h01}}}, 2'b00, 1'b1,
              16'hFFFF, "R3 R4 byte min unsigned dest");
        do_op({16{8'hF0}}, {16{8'h80}}, 2'b00, 1'b0, 16'hFFFF, "R3 byte max high dest");
        // R1 16-bit lanes with most negative value
        do_op({8{16'h7000}}, {16'h8000, 16'hFFFF, 16'h9000, {5{16'h0123}}}, 2'b01, 1'b0,
              16'hFFFF, "R1 R2 half max");
        do_op({8{16'h8001}}, {8{16'h8000}}, 2'b01, 1'b1, 16'hFFFF, "R2 R4 half min");
        // R1 32-bit lanes
        do_op({32'h0000_0010, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1}, {32'h8000_0000,
              32'h8000_0000, 32'hFFFF_FFFE, 32'h7FFF_FFFF}, 2'b10, 1'b0, 16'hFFFF,
              "R1 R2 word max");
        do_op({32'h0000_0010, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1}, {32'h8000_0000,
              32'h8000_0000, 32'hFFFF_FFFE, 32'h7FFF_FFFF}, 2'b10, 1'b1, 16'hFFFF,
              "R1 R4 word min");
        // R5 partial predicate inside wide lanes, and all-off
        do_op({4{32'h0000_0001}}, {4{32'h8000_0000}}, 2'b10, 1'b0, 16'b1010_0110_0001_1000,
              "R5 word partial predicate");
        do_op({8{16'h0001}}, {8{16'hF00F}}, 2'b01, 1'b0, 16'h5A5A, "R5 half partial predicate");
        do_op({16{8'h3C}}, {16{8'h80}}, 2'b00, 1'b0, 16'h0000, "R5 predicate all off");
        // R8 reserved size, then back to legal
        do_op({8{16'hBEEF}}, {16{8'h80}}, 2'b11, 1'b0, 16'hFFFF, "R8 reserved size");
        do_op({8{16'hBEEF}}, {16{8'h80}}, 2'b00, 1'b0, 16'hFFFF, "R8 legal after reserved");

        // R6 back-to-back random operations
        for (int i = 0; i < 40; i++) begin
            do_op({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom,
                  $urandom}, 2'($urandom % 4), 1'($urandom), 16'($urandom), "R6 back-to-back");
        end

        // R7 hold while idle
        begin
            logic [127:0] held;
            @(negedge clk);
            held = vd_o;
            vd_i = ~vd_i; vm_i = ~vm_i; pred_i = 16'hFFFF; size_i = 2'b00;
            repeat (4) @(negedge clk);
            check(vd_o === held, "R7 idle hold", vd_o, held);
            check(done_o === 1'b0, "R7 idle no done", {127'd0, done_o}, 128'd0);
        end
        check(sbq.size() == 0, "R6 every start produced done", 128'(sbq.size()), 128'd0);

        // R9 reset in mid-run
        do_op({16{8'hAA}}, {16{8'h80}}, 2'b11, 1'b0, 16'hFFFF, "R8 before reset");
        rst = 1'b1;
        @(negedge clk);
        check(vd_o === '0 && done_o === 1'b0 && illegal_o === 1'b0, "R9 reset clears",
              {vd_o[125:0], done_o, illegal_o}, 128'd0);
        sbq.delete();
        rst = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule